// File: doc/BRIEF.md
# Deep-Sleep Wakeup Source Controller

This block keeps the set of armed wakeup sources for a chip that enters deep sleep, and after a wakeup reports which source brought the system back. Five sources can be armed: two external pin events (called ext0 and ext1), a sleep timer, the touch sensor and a request from the low-power coprocessor. Software arms and disarms sources through a one-command-per-cycle port. Each command gets a registered response one cycle later. Some combinations cannot coexist. Commands that would create such a combination, or that carry an illegal argument, are refused and leave the stored state as it was.

A small state machine follows the sleep cycle through three states. `ST_AWAKE` is the state after reset. `ST_ASLEEP` is entered on `sleep_enter`, from either of the other two states, and clears the captured cause. `ST_WOKEN` is entered from `ST_ASLEEP` on `wake_strobe`; in that transition the raw events are masked by the armed sources and captured, together with the ext1 pin snapshot. `ST_WOKEN` returns to `ST_ASLEEP` on the next `sleep_enter`. In every other case the state holds.

A combinational decoder turns the captured vector into one cause code, using fixed priority. The code is forced to "undefined" unless the reset reason input says the last reset came from deep sleep. The decoder also derives the touch pad index and the ext1 status from the decoded cause.

Top module: `wake_src_ctrl`

## Requirements
- R1: Source index encoding on `cmd_src` and in the bit positions of `trig_en` and `wake_events`: 0 ext0, 1 ext1, 2 timer, 3 touch, 4 coprocessor. A command with `cmd_clear`=0 sets the bit of the source and a command with `cmd_clear`=1 clears it. The command is sampled on a clock edge. From that edge on, `rsp_valid` is high for one cycle, `rsp_code` is 0 (OK) and `trig_en` holds the new value.
- R2: Arming touch (3) or coprocessor (4) while ext0 is armed returns `rsp_code`=1 (invalid state), and `trig_en` is unchanged.
- R3: Arming ext0 while touch or coprocessor is armed returns `rsp_code`=1, and `trig_en` is unchanged.
- R4: When arming ext0, `cmd_level` values 0 and 1 are stored on `ext0_level`. Values 2 and 3 return `rsp_code`=2 (invalid argument) and leave `trig_en` and `ext0_level` unchanged. The argument check comes before the conflict check.
- R5: A `cmd_src` above 4 returns `rsp_code`=2 for both setting and clearing, and changes nothing.
- R6: After reset, `trig_en` is 0, `ext0_level` is 0, `rsp_valid` is 0 and `cause_code` is 0.
- R7: `cause_code` is 0 (undefined) whenever `deep_sleep_rst` is low.
- R8: Cause codes are 0 undefined, 1 ext0, 2 ext1, 3 timer, 4 touch and 5 coprocessor. When several captured bits are set, the lowest source index wins. When no captured bit is set, the code is 0.
- R9: When `cause_code` is 4, `touch_pad` is the index of the lowest set bit of `touch_meas_en`, or NUM_PADS if that mask is zero. For any other cause it is NUM_PADS.
- R10: `ext1_status` shows the `ext1_pins` value captured at the wake strobe when `cause_code` is 2, and is zero otherwise.
- R11: A `wake_strobe` in `ST_ASLEEP` captures `wake_events & trig_en` on that edge. Events of sources that are not armed are ignored. A `wake_strobe` outside `ST_ASLEEP` has no effect. The capture holds until `sleep_enter`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_clear | input | 1 | 1 disarms the source, 0 arms it |
| cmd_src | input | 3 | Source index |
| cmd_level | input | 2 | Trigger level for ext0 arming |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_code | output | 2 | 0 OK, 1 invalid state, 2 invalid argument |
| trig_en | output | 5 | Armed sources |
| ext0_level | output | 1 | Stored ext0 trigger level |
| sleep_enter | input | 1 | Sleep entry strobe |
| wake_strobe | input | 1 | Wake capture strobe |
| wake_events | input | 5 | Raw source events at wakeup |
| ext1_pins | input | EXT1_W | Ext1 pin snapshot |
| touch_meas_en | input | NUM_PADS | Touch measure enable mask |
| deep_sleep_rst | input | 1 | Last reset came from deep sleep |
| cause_code | output | 3 | Decoded wakeup cause |
| touch_pad | output | $clog2(NUM_PADS+1) | Touch pad index or NUM_PADS |
| ext1_status | output | EXT1_W | Captured ext1 pins when the cause is ext1 |

## Verification
The assertions take for granted that `cmd_src`, `wake_strobe` and `sleep_enter` are known after reset and that `deep_sleep_rst` and `touch_meas_en` do not change while outputs are sampled. The stimulus drives every input on the falling edge and holds it steady across the rising edge. It also keeps a strobe high for exactly one cycle, so a single capture never spans two edges. The bench sweeps every target arming mask and every event pattern. It computes the expected responses, the surviving mask and the priority cause in its own model.

// File: rtl/wake_src_pkg.sv
package wake_src_pkg;
    localparam int SRC_COUNT = 5;

    typedef enum logic [2:0] {
        SRC_EXT0  = 3'd0,
        SRC_EXT1  = 3'd1,
        SRC_TIMER = 3'd2,
        SRC_TOUCH = 3'd3,
        SRC_COPRO = 3'd4
    } src_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_EXT0  = 3'd1,
        CAUSE_EXT1  = 3'd2,
        CAUSE_TIMER = 3'd3,
        CAUSE_TOUCH = 3'd4,
        CAUSE_COPRO = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        RSP_OK        = 2'd0,
        RSP_BAD_STATE = 2'd1,
        RSP_BAD_ARG   = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_WOKEN  = 2'd2
    } sleep_st_e;
endpackage

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
    import wake_src_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_clear,
    input  logic [2:0]           cmd_src,
    input  logic [1:0]           cmd_level,
    output logic                 rsp_valid,
    output rsp_e                 rsp_code,
    output logic [SRC_COUNT-1:0] trig_en,
    output logic                 ext0_level
);
    rsp_e                 verdict;
    logic [SRC_COUNT-1:0] next_en;
    logic                 next_lvl;
    logic                 excl_touchy;

    assign excl_touchy = trig_en[SRC_TOUCH] | trig_en[SRC_COPRO];

    always_comb begin
        verdict  = RSP_OK;
        next_en  = trig_en;
        next_lvl = ext0_level;
        if (cmd_src > SRC_COPRO) begin
            verdict = RSP_BAD_ARG;
        end else if (cmd_clear) begin
            next_en[cmd_src] = 1'b0;
        end else if (cmd_src == SRC_EXT0 && cmd_level[1]) begin
            verdict = RSP_BAD_ARG;
        end else if (cmd_src == SRC_EXT0 && excl_touchy) begin
            verdict = RSP_BAD_STATE;
        end else if ((cmd_src == SRC_TOUCH || cmd_src == SRC_COPRO) && trig_en[SRC_EXT0]) begin
            verdict = RSP_BAD_STATE;
        end else begin
            next_en[cmd_src] = 1'b1;
            if (cmd_src == SRC_EXT0) next_lvl = cmd_level[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_en    <= '0;
            ext0_level <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_code   <= RSP_OK;
        end else begin
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                rsp_code <= verdict;
                if (verdict == RSP_OK) begin
                    trig_en    <= next_en;
                    ext0_level <= next_lvl;
                end
            end
        end
    end

    assert_no_conflict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_en[SRC_EXT0] && (trig_en[SRC_TOUCH] || trig_en[SRC_COPRO])));

    assert_reject_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != RSP_OK) |-> ($stable(trig_en) && $stable(ext0_level)));

    assert_rsp_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
endmodule

// File: rtl/wake_sleep_fsm.sv
module wake_sleep_fsm
    import wake_src_pkg::*;
#(
    parameter int EXT1_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_enter,
    input  logic                 wake_strobe,
    input  logic [SRC_COUNT-1:0] wake_events,
    input  logic [SRC_COUNT-1:0] trig_en,
    input  logic [EXT1_W-1:0]    ext1_pins,
    output logic [SRC_COUNT-1:0] cause_vec,
    output logic [EXT1_W-1:0]    ext1_snap
);
    sleep_st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE:  if (sleep_enter) state_nx = ST_ASLEEP;
            ST_ASLEEP: if (wake_strobe) state_nx = ST_WOKEN;
            ST_WOKEN:  if (sleep_enter) state_nx = ST_ASLEEP;
            default:   state_nx = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_vec <= '0;
            ext1_snap <= '0;
        end else begin
            unique case (state)
                ST_ASLEEP: if (wake_strobe) begin
                    cause_vec <= wake_events & trig_en;
                    ext1_snap <= ext1_pins;
                end
                ST_AWAKE, ST_WOKEN: if (sleep_enter) begin
                    cause_vec <= '0;
                    ext1_snap <= '0;
                end
                default: ;
            endcase
        end
    end

    assert_stray_strobe_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ASLEEP && wake_strobe && !sleep_enter) |=> $stable(cause_vec));

    assert_capture_armed_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ASLEEP && wake_strobe) |=> ((cause_vec & ~$past(trig_en)) == '0));

    assert_sleep_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ASLEEP && sleep_enter) |=> (cause_vec == '0));
endmodule

// File: rtl/wake_cause_decode.sv
module wake_cause_decode
    import wake_src_pkg::*;
#(
    parameter int NUM_PADS = 10,
    parameter int EXT1_W   = 8,
    localparam int PAD_W   = $clog2(NUM_PADS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] cause_vec,
    input  logic                 deep_sleep_rst,
    input  logic [NUM_PADS-1:0]  touch_meas_en,
    input  logic [EXT1_W-1:0]    ext1_snap,
    output cause_e               cause_code,
    output logic [PAD_W-1:0]     touch_pad,
    output logic [EXT1_W-1:0]    ext1_status
);
    always_comb begin
        cause_code = CAUSE_NONE;
        if (deep_sleep_rst) begin
            for (int i = SRC_COUNT - 1; i >= 0; i--) begin
                if (cause_vec[i]) cause_code = cause_e'(3'(i + 1));
            end
        end
    end

    always_comb begin
        touch_pad = PAD_W'(NUM_PADS);
        if (cause_code == CAUSE_TOUCH) begin
            for (int p = NUM_PADS - 1; p >= 0; p--) begin
                if (touch_meas_en[p]) touch_pad = PAD_W'(p);
            end
        end
    end

    assign ext1_status = (cause_code == CAUSE_EXT1) ? ext1_snap : '0;

    assert_gated_by_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_code != CAUSE_NONE) |-> deep_sleep_rst);

    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cause_code <= CAUSE_COPRO);

    assert_pad_sentinel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_code != CAUSE_TOUCH) |-> (touch_pad == PAD_W'(NUM_PADS)));

    assert_ext1_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext1_status != '0) |-> (cause_code == CAUSE_EXT1));
endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
    import wake_src_pkg::*;
#(
    parameter int NUM_PADS = 10,
    parameter int EXT1_W   = 8,
    localparam int PAD_W   = $clog2(NUM_PADS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_clear,
    input  logic [2:0]           cmd_src,
    input  logic [1:0]           cmd_level,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code,
    output logic [SRC_COUNT-1:0] trig_en,
    output logic                 ext0_level,
    input  logic                 sleep_enter,
    input  logic                 wake_strobe,
    input  logic [SRC_COUNT-1:0] wake_events,
    input  logic [EXT1_W-1:0]    ext1_pins,
    input  logic [NUM_PADS-1:0]  touch_meas_en,
    input  logic                 deep_sleep_rst,
    output logic [2:0]           cause_code,
    output logic [PAD_W-1:0]     touch_pad,
    output logic [EXT1_W-1:0]    ext1_status
);
    rsp_e                 rsp_e_w;
    cause_e               cause_e_w;
    logic [SRC_COUNT-1:0] cause_vec;
    logic [EXT1_W-1:0]    ext1_snap;

    wake_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_clear  (cmd_clear),
        .cmd_src    (cmd_src),
        .cmd_level  (cmd_level),
        .rsp_valid  (rsp_valid),
        .rsp_code   (rsp_e_w),
        .trig_en    (trig_en),
        .ext0_level (ext0_level)
    );

    wake_sleep_fsm #(.EXT1_W(EXT1_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_enter (sleep_enter),
        .wake_strobe (wake_strobe),
        .wake_events (wake_events),
        .trig_en     (trig_en),
        .ext1_pins   (ext1_pins),
        .cause_vec   (cause_vec),
        .ext1_snap   (ext1_snap)
    );

    wake_cause_decode #(.NUM_PADS(NUM_PADS), .EXT1_W(EXT1_W)) u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .cause_vec      (cause_vec),
        .deep_sleep_rst (deep_sleep_rst),
        .touch_meas_en  (touch_meas_en),
        .ext1_snap      (ext1_snap),
        .cause_code     (cause_e_w),
        .touch_pad      (touch_pad),
        .ext1_status    (ext1_status)
    );

    assign rsp_code   = rsp_e_w;
    assign cause_code = cause_e_w;
endmodule

// File: tb/sim_wake_src_ctrl.sv
module sim_wake_src_ctrl;
    localparam int NP = 10;
    localparam int EW = 8;
    localparam int PW = $clog2(NP + 1);

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_clear = 0;
    logic [2:0] cmd_src = 0;
    logic [1:0] cmd_level = 0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic [4:0] trig_en;
    logic ext0_level;
    logic sleep_enter = 0, wake_strobe = 0;
    logic [4:0] wake_events = 0;
    logic [EW-1:0] ext1_pins = 0;
    logic [NP-1:0] touch_meas_en = 0;
    logic deep_sleep_rst = 1;
    logic [2:0] cause_code;
    logic [PW-1:0] touch_pad;
    logic [EW-1:0] ext1_status;

    int n_chk = 0, n_bad = 0;
    logic [4:0] m_en = 0;
    logic m_lvl = 0;

    always #10 clk = ~clk;

    wake_src_ctrl #(.NUM_PADS(NP), .EXT1_W(EW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    function automatic int exp_cause(input logic [4:0] v, input logic dsr);
        if (!dsr) return 0;
        for (int i = 0; i < 5; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    // Model of the command rules (R1..R5); returns expected code and updates model state.
    function automatic int model_cmd(input bit clr, input int src, input int lvl);
        if (src > 4) return 2;
        if (clr) begin m_en[src] = 1'b0; return 0; end
        if (src == 0 && lvl > 1) return 2;
        if (src == 0 && (m_en[3] || m_en[4])) return 1;
        if ((src == 3 || src == 4) && m_en[0]) return 1;
        m_en[src] = 1'b1;
        if (src == 0) m_lvl = lvl[0];
        return 0;
    endfunction

    task automatic cmd(input bit clr, input int src, input int lvl, input string req);
        int e;
        e = model_cmd(clr, src, lvl);
        @(negedge clk);
        cmd_valid = 1; cmd_clear = clr; cmd_src = 3'(src); cmd_level = 2'(lvl);
        @(negedge clk);
        cmd_valid = 0;
        chk(rsp_valid === 1'b1, req, int'(rsp_valid), 1);
        chk(rsp_code == 2'(e), req, int'(rsp_code), e);
        chk(trig_en == m_en, req, int'(trig_en), int'(m_en));
        chk(ext0_level == m_lvl, req, int'(ext0_level), int'(m_lvl));
    endtask

    task automatic sleep_wake(input logic [4:0] ev, input logic [EW-1:0] pins);
        @(negedge clk); sleep_enter = 1;
        @(negedge clk); sleep_enter = 0; wake_strobe = 1; wake_events = ev; ext1_pins = pins;
        @(negedge clk); wake_strobe = 0; wake_events = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int lo;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(trig_en == 0, "R6", int'(trig_en), 0);
        chk(ext0_level == 0, "R6", int'(ext0_level), 0);
        chk(rsp_valid == 0, "R6", int'(rsp_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(cause_code == 0, "R6", int'(cause_code), 0);

        // R5 out-of-range sources
        for (int s = 5; s < 8; s++) begin
            cmd(0, s, 0, "R5");
            cmd(1, s, 0, "R5");
        end
        // R4 bad levels, then good levels
        cmd(0, 0, 2, "R4"); cmd(0, 0, 3, "R4");
        cmd(0, 0, 1, "R4"); cmd(0, 0, 3, "R4");
        cmd(0, 0, 0, "R4");
        // R2 conflict from ext0 side
        cmd(0, 3, 0, "R2"); cmd(0, 4, 0, "R2");
        cmd(1, 0, 0, "R1");
        cmd(0, 3, 0, "R1");
        // R3 conflict and R4 order (arg check before conflict)
        cmd(0, 0, 1, "R3"); cmd(0, 0, 2, "R4");
        cmd(1, 3, 0, "R1"); cmd(0, 4, 0, "R1"); cmd(0, 0, 0, "R3");

        // Exhaustive sweep: every target mask, every event pattern
        for (int m = 0; m < 32; m++) begin
            for (int s = 0; s < 5; s++) cmd(1, s, 0, "R1");
            for (int s = 0; s < 5; s++) if (m[s]) cmd(0, s, m % 2, (s == 0) ? "R3" : "R2");
            for (int ev = 0; ev < 32; ev++) begin
                sleep_wake(5'(ev), 8'h00);
                chk(cause_code == 3'(exp_cause(5'(ev) & m_en, 1)), "R8",
                    int'(cause_code), exp_cause(5'(ev) & m_en, 1));
            end
        end

        // R7 reset-reason gating
        for (int s = 0; s < 5; s++) cmd(1, s, 0, "R1");
        cmd(0, 2, 0, "R1");
        sleep_wake(5'b00100, 8'h00);
        deep_sleep_rst = 0; #1;
        chk(cause_code == 0, "R7", int'(cause_code), 0);
        deep_sleep_rst = 1; #1;
        chk(cause_code == 3, "R7", int'(cause_code), 3);

        // R11 stray strobe in woken state is ignored, sleep entry clears
        @(negedge clk); wake_strobe = 1; wake_events = 5'b11111;
        @(negedge clk); wake_strobe = 0; wake_events = 0;
        chk(cause_code == 3, "R11", int'(cause_code), 3);
        @(negedge clk); sleep_enter = 1;
        @(negedge clk); sleep_enter = 0;
        chk(cause_code == 0, "R11", int'(cause_code), 0);

        // R10 ext1 status
        cmd(0, 1, 0, "R1");
        sleep_wake(5'b00110, 8'hA5);
        chk(cause_code == 2, "R10", int'(cause_code), 2);
        chk(ext1_status == 8'hA5, "R10", int'(ext1_status), 'hA5);
        sleep_wake(5'b00100, 8'h5A);
        chk(ext1_status == 0, "R10", int'(ext1_status), 0);
        chk(touch_pad == PW'(NP), "R9", int'(touch_pad), NP);

        // R9 touch pad sweep
        for (int s = 0; s < 5; s++) cmd(1, s, 0, "R1");
        cmd(0, 3, 0, "R1");
        sleep_wake(5'b01000, 8'h00);
        for (int t = 0; t < (1 << NP); t++) begin
            touch_meas_en = NP'(t); #1;
            lo = NP;
            for (int b = NP - 1; b >= 0; b--) if (t[b]) lo = b;
            chk(touch_pad == PW'(lo), "R9", int'(touch_pad), lo);
        end
        deep_sleep_rst = 0; #1;
        chk(touch_pad == PW'(NP), "R9", int'(touch_pad), NP);
        deep_sleep_rst = 1;

        finish_run();
    end
endmodule